// File: doc/BRIEF.md
# Adaptive Bank-to-Cluster Folding Network

This block sits between a set of memory-bank stream ports and an equal number of identical compute clusters. With enough data parallelism every bank streams straight into its own cluster. When a loop, after unrolling, has fewer iterations than there are clusters, the block folds the bank streams onto a smaller set of clusters. Two or four banks then share one cluster, taking turns. The clusters left over receive power-off enables and are fed nothing.

The fold is picked from the unrolled trip count that comes with a reconfigure request. The request is held until every bank port has dropped its valid, so no transfer is ever cut in half. Each bank and each cluster port uses a valid/ready/data handshake. The block holds no data. A word moves from a bank to its cluster in the same cycle that the cluster is ready and it is that bank's turn.

Top module: `cmux_fold_net`

## Requirements
- R1: The fold follows the trip count of the applied request. A count of at least 4 keeps all clusters on (`clu_pwr_en` = 4'b1111). A count of 2 or 3 keeps clusters 0 and 1 on (4'b0011). A count of 1 keeps cluster 0 on (4'b0001). A count of 0 turns every cluster off (4'b0000). Bit c of `clu_pwr_en` belongs to cluster c.
- R2: With all clusters on, bank b goes to cluster b. `clu_vld[b]` equals `bank_vld[b]`, and `bank_rdy[b]` equals `bank_vld[b] & clu_rdy[b]`.
- R3: With two clusters on, cluster 0 serves banks 0 and 2, and cluster 1 serves banks 1 and 3.
- R4: With one cluster on, cluster 0 serves all four banks.
- R5: Banks that share a cluster are served round-robin. After reset or after a reconfiguration, the lowest-numbered bank has first turn. After each transfer, the turn passes to the next bank in index order, and banks with no valid are skipped.
- R6: `bank_rdy` is high only for a bank that has valid, whose turn it is, and whose cluster is ready. A cluster that is not ready keeps the turn where it is.
- R7: A cluster that is off, or has no bank to serve, shows `clu_vld` low and `clu_data` all zero. The `clu_rdy` of an off cluster has no effect.
- R8: A reconfigure request takes effect at the first clock edge where no bank has valid, which may be the edge that samples the request. If another request arrives while one is waiting, the later trip count wins. Transfers continue as normal while a request waits.
- R9: Reset puts the block in the all-on fold, with every round-robin turn at the lowest bank.
- R10: Each word accepted from a bank appears exactly once, in order, as a transfer on its cluster. The number of bank handshakes in a cycle always equals the number of cluster handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_req | input | 1 | Reconfigure request, one cycle |
| cfg_trip | input | TRIP_W | Unrolled loop trip count sent with the request |
| bank_vld | input | CLUSTERS | Per-bank word valid |
| bank_rdy | output | CLUSTERS | Per-bank word accepted |
| bank_data | input | CLUSTERS*DATA_W | Bank words, bank b at bits [b*DATA_W +: DATA_W] |
| clu_vld | output | CLUSTERS | Per-cluster word valid |
| clu_rdy | input | CLUSTERS | Per-cluster ready |
| clu_data | output | CLUSTERS*DATA_W | Cluster words, cluster c at bits [c*DATA_W +: DATA_W] |
| clu_pwr_en | output | CLUSTERS | Per-cluster power enable |

## Verification
A waiting reconfiguration and a round-robin transfer can occur in the same cycle. A bank keeps streaming while a request is pending, and the fold may only change once every bank valid is low. The bench provokes this by pulsing the request, and then pulsing a second one, while bank 0 holds valid against a ready cluster. It then checks that the word still passes in that cycle, that the power enables keep the old fold for as long as any valid stays high, and that the second trip count is the one applied on the first idle edge. A separate folded stream with a stalling cluster checks that no word is lost or repeated when the turns rotate and the ready signal drops.

// File: rtl/cmux_pkg.sv
// Shared types and helpers for the bank-to-cluster folding network.
// Assumes the cluster count is a multiple of four.
package cmux_pkg;

    // Fold applied to the bank streams.
    typedef enum logic [1:0] {
        FOLD_NONE    = 2'd0,
        FOLD_HALF    = 2'd1,
        FOLD_QUARTER = 2'd2,
        FOLD_DARK    = 2'd3
    } fold_t;

    // Largest number of banks that can share one cluster.
    localparam int MAX_SHARE = 4;

    // Number of clusters kept powered under a fold.
    function automatic int lanes_on(input fold_t f, input int n);
        case (f)
            FOLD_NONE:    return n;
            FOLD_HALF:    return n / 2;
            FOLD_QUARTER: return n / 4;
            default:      return 0;
        endcase
    endfunction

    // Number of banks that share one powered cluster under a fold.
    function automatic int share_of(input fold_t f);
        case (f)
            FOLD_HALF:    return 2;
            FOLD_QUARTER: return 4;
            default:      return 1;
        endcase
    endfunction

endpackage

// File: rtl/cmux_fold_ctrl.sv
// Fold controller: holds the current fold, parks a reconfigure request
// until every bank port is idle, then applies the fold picked from the
// most recent trip count. Drives the per-cluster power enables.
// Assumes the banks eventually drop valid so that a waiting request can land.
module cmux_fold_ctrl
    import cmux_pkg::*;
#(
    parameter int CLUSTERS = 4,
    parameter int TRIP_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_req,
    input  logic [TRIP_W-1:0]   cfg_trip,
    input  logic [CLUSTERS-1:0] bank_vld,
    output fold_t               fold_q,
    output logic                apply,
    output logic [CLUSTERS-1:0] pwr_en
);

    logic              pend_q;
    logic [TRIP_W-1:0] trip_q;
    logic [TRIP_W-1:0] eff_trip;
    logic [31:0]       trip_ext;
    logic              idle;
    fold_t             fold_nxt;

    // Pick the fold for the trip count that would be applied now.
    always_comb begin
        idle     = ~|bank_vld;
        apply    = (cfg_req | pend_q) & idle;
        eff_trip = cfg_req ? cfg_trip : trip_q;
        trip_ext = 32'(eff_trip);
        if (trip_ext >= 32'(CLUSTERS))          fold_nxt = FOLD_NONE;
        else if (trip_ext >= 32'(CLUSTERS / 2)) fold_nxt = FOLD_HALF;
        else if (trip_ext != 32'd0)             fold_nxt = FOLD_QUARTER;
        else                                    fold_nxt = FOLD_DARK;
    end

    // Power enables form a prefix of the cluster indices.
    always_comb begin
        for (int c = 0; c < CLUSTERS; c++) begin
            pwr_en[c] = (c < lanes_on(fold_q, CLUSTERS));
        end
    end

    // Park requests, keep the latest trip count, land the fold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            trip_q <= '0;
            fold_q <= FOLD_NONE;
        end else begin
            if (cfg_req) trip_q <= cfg_trip;
            pend_q <= apply ? 1'b0 : (pend_q | cfg_req);
            if (apply) fold_q <= fold_nxt;
        end
    end

    // R8: the fold only moves on an edge that saw every bank idle.
    p_fold_moves_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fold_q) |-> $past(idle));

    // R1: the powered clusters are always a contiguous run from cluster 0.
    p_pwr_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_en + 1'b1) & pwr_en) == '0);

endmodule

// File: rtl/cmux_lane.sv
// One cluster lane: finds the banks folded onto this cluster, serves them
// round-robin starting at the turn pointer, and forwards the chosen word.
// Assumes a bank holds valid and data steady until it sees ready.
module cmux_lane
    import cmux_pkg::*;
#(
    parameter int CLUSTERS = 4,
    parameter int DATA_W   = 32,
    parameter int IDX      = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  fold_t               fold,
    input  logic                apply,
    input  logic                pwr,
    input  logic [CLUSTERS-1:0] bank_vld,
    input  logic [DATA_W-1:0]   bank_word [CLUSTERS],
    input  logic                clu_rdy,
    output logic                lane_vld,
    output logic [DATA_W-1:0]   lane_data,
    output logic [CLUSTERS-1:0] gnt
);

    localparam int BW = (CLUSTERS > 1) ? $clog2(CLUSTERS) : 1;
    localparam int SW = $clog2(MAX_SHARE);

    logic [MAX_SHARE-1:0] req;
    logic [BW-1:0]        slot_bank [MAX_SHARE];
    logic [SW-1:0]        ptr_q;
    logic [SW-1:0]        sel_slot;
    logic [SW-1:0]        probe;
    logic [SW-1:0]        share_mask;
    logic [BW-1:0]        bank_sel;
    int                   act;
    int                   share;

    // Map each slot of this lane to its bank and mark the slots asking.
    always_comb begin
        act        = lanes_on(fold, CLUSTERS);
        share      = share_of(fold);
        share_mask = SW'(share - 1);
        for (int k = 0; k < MAX_SHARE; k++) begin
            slot_bank[k] = BW'((IDX + k * act) % CLUSTERS);
            req[k] = pwr && (k < share) && ((IDX + k * act) < CLUSTERS)
                     && bank_vld[slot_bank[k]];
        end
    end

    // Take the first asking slot at or after the turn pointer.
    always_comb begin
        lane_vld = 1'b0;
        sel_slot = '0;
        probe    = '0;
        for (int j = 0; j < MAX_SHARE; j++) begin
            probe = (ptr_q + SW'(j)) & share_mask;
            if (!lane_vld && req[probe]) begin
                lane_vld = 1'b1;
                sel_slot = probe;
            end
        end
        bank_sel  = slot_bank[sel_slot];
        lane_data = lane_vld ? bank_word[bank_sel] : '0;
        gnt       = '0;
        if (lane_vld) gnt[bank_sel] = 1'b1;
    end

    // Hand the turn to the slot after the one served; restart on refold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (apply) begin
            ptr_q <= '0;
        end else if (lane_vld && clu_rdy) begin
            ptr_q <= (sel_slot + 1'b1) & share_mask;
        end
    end

    // R7: a lane whose cluster is off shows no valid and no data.
    p_dark_lane_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr |-> (!lane_vld && lane_data == '0));

endmodule

// File: rtl/cmux_fold_net.sv
// Top of the bank-to-cluster folding network. Unpacks the bank words,
// builds one lane per cluster, and merges the lane grants with the
// cluster readies into the per-bank ready lines.
// Assumes CLUSTERS is a multiple of four; no data is stored inside.
module cmux_fold_net
    import cmux_pkg::*;
#(
    parameter int CLUSTERS = 4,
    parameter int DATA_W   = 32,
    parameter int TRIP_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_req,
    input  logic [TRIP_W-1:0]            cfg_trip,
    input  logic [CLUSTERS-1:0]          bank_vld,
    output logic [CLUSTERS-1:0]          bank_rdy,
    input  logic [CLUSTERS*DATA_W-1:0]   bank_data,
    output logic [CLUSTERS-1:0]          clu_vld,
    input  logic [CLUSTERS-1:0]          clu_rdy,
    output logic [CLUSTERS*DATA_W-1:0]   clu_data,
    output logic [CLUSTERS-1:0]          clu_pwr_en
);

    fold_t               fold;
    logic                apply;
    logic [DATA_W-1:0]   bank_word [CLUSTERS];
    logic [CLUSTERS-1:0] gnt_m [CLUSTERS];

    cmux_fold_ctrl #(.CLUSTERS(CLUSTERS), .TRIP_W(TRIP_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_req  (cfg_req),
        .cfg_trip (cfg_trip),
        .bank_vld (bank_vld),
        .fold_q   (fold),
        .apply    (apply),
        .pwr_en   (clu_pwr_en)
    );

    for (genvar c = 0; c < CLUSTERS; c++) begin : g_lane
        assign bank_word[c] = bank_data[c*DATA_W +: DATA_W];

        cmux_lane #(.CLUSTERS(CLUSTERS), .DATA_W(DATA_W), .IDX(c)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .fold      (fold),
            .apply     (apply),
            .pwr       (clu_pwr_en[c]),
            .bank_vld  (bank_vld),
            .bank_word (bank_word),
            .clu_rdy   (clu_rdy[c]),
            .lane_vld  (clu_vld[c]),
            .lane_data (clu_data[c*DATA_W +: DATA_W]),
            .gnt       (gnt_m[c])
        );
    end

    // A bank is accepted when some lane grants it and that cluster is ready.
    always_comb begin
        bank_rdy = '0;
        for (int b = 0; b < CLUSTERS; b++) begin
            for (int c = 0; c < CLUSTERS; c++) begin
                bank_rdy[b] = bank_rdy[b] | (gnt_m[c][b] & clu_rdy[c]);
            end
        end
    end

    // R6: no bank is told ready unless it is offering a word.
    p_rdy_needs_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rdy & ~bank_vld) == '0);

    // R10: bank handshakes and cluster handshakes match one for one.
    p_xfer_balance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_rdy) == $countones(clu_vld & clu_rdy));

endmodule

// File: tb/cmux_fold_net_test.sv
// Bench for the folding network: a vector table of single-cycle routing
// cases (each after a fresh refold), then directed tests for reset,
// rotation, stalls, deferred refold and a lossless folded stream.
module cmux_fold_net_test;

    localparam int N = 4;
    localparam int W = 32;
    localparam int T = 8;
    localparam int ROWS = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_req = 1'b0;
    logic [T-1:0]   cfg_trip = '0;
    logic [N-1:0]   bank_vld = '0;
    logic [N-1:0]   bank_rdy;
    logic [N*W-1:0] bank_data = '0;
    logic [N-1:0]   clu_vld;
    logic [N-1:0]   clu_rdy = '0;
    logic [N*W-1:0] clu_data;
    logic [N-1:0]   clu_pwr_en;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cmux_fold_net #(.CLUSTERS(N), .DATA_W(W), .TRIP_W(T)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_trip(cfg_trip),
        .bank_vld(bank_vld), .bank_rdy(bank_rdy), .bank_data(bank_data),
        .clu_vld(clu_vld), .clu_rdy(clu_rdy), .clu_data(clu_data),
        .clu_pwr_en(clu_pwr_en)
    );

    // Row: trip, bank_vld, clu_rdy, exp pwr, exp clu_vld, exp bank_rdy,
    // source bank per cluster (cluster 3..0, 7 = all-zero data).
    localparam logic [39:0] VEC [ROWS] = '{
        {8'd4,   4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 3'd3, 3'd2, 3'd1, 3'd0}, // R2
        {8'd9,   4'b0101, 4'b0111, 4'b1111, 4'b0101, 4'b0101, 3'd7, 3'd2, 3'd7, 3'd0}, // R2 R7
        {8'd2,   4'b1111, 4'b0011, 4'b0011, 4'b0011, 4'b0011, 3'd7, 3'd7, 3'd1, 3'd0}, // R3
        {8'd3,   4'b1100, 4'b0011, 4'b0011, 4'b0011, 4'b1100, 3'd7, 3'd7, 3'd3, 3'd2}, // R3
        {8'd2,   4'b1111, 4'b0001, 4'b0011, 4'b0011, 4'b0001, 3'd7, 3'd7, 3'd1, 3'd0}, // R6
        {8'd1,   4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 3'd7, 3'd7, 3'd7, 3'd0}, // R4
        {8'd1,   4'b1000, 4'b1111, 4'b0001, 4'b0001, 4'b1000, 3'd7, 3'd7, 3'd7, 3'd3}, // R4 R7
        {8'd0,   4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 3'd7, 3'd7, 3'd7, 3'd7}, // R1 R7
        {8'd1,   4'b0110, 4'b0001, 4'b0001, 4'b0001, 4'b0010, 3'd7, 3'd7, 3'd7, 3'd1}, // R5
        {8'd200, 4'b1010, 4'b0000, 4'b1111, 4'b1010, 4'b0000, 3'd3, 3'd7, 3'd1, 3'd7}  // R1 R6
    };

    function automatic logic [W-1:0] word_of(input int b);
        return 32'hC0DE_0000 | 32'(b);
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_words();
        for (int b = 0; b < N; b++) bank_data[b*W +: W] = word_of(b);
    endtask

    // Refold with all banks idle; the request lands on this edge.
    task automatic refold(input int trip);
        bank_vld = '0;
        cfg_req  = 1'b1;
        cfg_trip = T'(trip);
        tick();
        cfg_req  = 1'b0;
    endtask

    task automatic check_data(input string req, input logic [11:0] src);
        for (int c = 0; c < N; c++) begin
            logic [2:0]   s;
            logic [W-1:0] e;
            s = src[3*c +: 3];
            e = (s == 3'd7) ? '0 : word_of(int'(s));
            check(clu_data[c*W +: W] == e, req, 64'(clu_data[c*W +: W]), 64'(e));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        load_words();
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R9 reset state: all clusters on, nothing moving.
        check(clu_pwr_en == 4'b1111, "R9 pwr", 64'(clu_pwr_en), 64'hf);
        check(clu_vld == 4'b0000, "R9 vld", 64'(clu_vld), 64'h0);
        check(bank_rdy == 4'b0000, "R9 rdy", 64'(bank_rdy), 64'h0);

        // Vector table walk.
        for (int i = 0; i < ROWS; i++) begin
            refold(int'(VEC[i][39:32]));
            bank_vld = VEC[i][31:28];
            clu_rdy  = VEC[i][27:24];
            #1;
            check(clu_pwr_en == VEC[i][23:20], "R1 table pwr", 64'(clu_pwr_en), 64'(VEC[i][23:20]));
            check(clu_vld == VEC[i][19:16], "R2 R3 R4 table vld", 64'(clu_vld), 64'(VEC[i][19:16]));
            check(bank_rdy == VEC[i][15:12], "R6 table rdy", 64'(bank_rdy), 64'(VEC[i][15:12]));
            check_data("R7 table data", VEC[i][11:0]);
            tick();
        end

        // R5 two-way fold: turns alternate on both clusters.
        refold(2);
        bank_vld = 4'b1111;
        clu_rdy  = 4'b0011;
        #1;
        check(bank_rdy == 4'b0011, "R5 half first", 64'(bank_rdy), 64'h3);
        tick(); #1;
        check(bank_rdy == 4'b1100, "R5 half second", 64'(bank_rdy), 64'hc);
        check_data("R5 half data", {3'd7, 3'd7, 3'd3, 3'd2});
        tick(); #1;
        check(bank_rdy == 4'b0011, "R5 half wrap", 64'(bank_rdy), 64'h3);
        tick();

        // R5 four-way fold: full rotation, then skipping idle banks.
        refold(1);
        bank_vld = 4'b1111;
        clu_rdy  = 4'b0001;
        for (int k = 0; k < 5; k++) begin
            #1;
            check(bank_rdy == 4'(1 << (k % 4)), "R5 rotate", 64'(bank_rdy), 64'(1 << (k % 4)));
            tick();
        end
        bank_vld = 4'b1010;   // turn now at bank 1
        #1;
        check(bank_rdy == 4'b0010, "R5 skip a", 64'(bank_rdy), 64'h2);
        tick(); #1;
        check(bank_rdy == 4'b1000, "R5 skip b", 64'(bank_rdy), 64'h8);
        tick(); #1;
        check(bank_rdy == 4'b0010, "R5 skip c", 64'(bank_rdy), 64'h2);
        tick();

        // R6 a stalled cluster keeps the turn.
        refold(1);
        bank_vld = 4'b1111;
        clu_rdy  = 4'b0000;
        #1;
        check(bank_rdy == 4'b0000 && clu_vld == 4'b0001, "R6 stall",
              64'({clu_vld, bank_rdy}), 64'h10);
        tick();
        clu_rdy = 4'b0001;
        #1;
        check(bank_rdy == 4'b0001, "R6 stall resume", 64'(bank_rdy), 64'h1);
        tick();

        // R8 deferred refold while bank 0 keeps streaming.
        refold(4);
        bank_vld = 4'b0001;
        clu_rdy  = 4'b1111;
        cfg_req  = 1'b1;
        cfg_trip = 8'd1;
        #1;
        check(bank_rdy == 4'b0001, "R8 transfer with request", 64'(bank_rdy), 64'h1);
        tick();
        cfg_req = 1'b0;
        #1;
        check(clu_pwr_en == 4'b1111, "R8 held busy", 64'(clu_pwr_en), 64'hf);
        tick();
        cfg_req  = 1'b1;
        cfg_trip = 8'd3;
        tick();
        cfg_req = 1'b0;
        #1;
        check(clu_pwr_en == 4'b1111, "R8 still held", 64'(clu_pwr_en), 64'hf);
        bank_vld = 4'b0000;
        tick(); #1;
        check(clu_pwr_en == 4'b0011, "R8 latest wins", 64'(clu_pwr_en), 64'h3);
        tick(); #1;
        check(clu_pwr_en == 4'b0011, "R8 no second change", 64'(clu_pwr_en), 64'h3);

        // R10 folded stream with a stalling cluster: each word once, in order.
        begin
            int sent [N];
            int rcv  [N];
            bit order_ok;
            order_ok = 1'b1;
            for (int b = 0; b < N; b++) begin
                sent[b] = 0;
                rcv[b]  = 0;
            end
            refold(1);
            for (int cyc = 0; cyc < 200; cyc++) begin
                for (int b = 0; b < N; b++) begin
                    bank_vld[b] = (sent[b] < 6);
                    bank_data[b*W +: W] = 32'((b << 8) | sent[b]);
                end
                clu_rdy = {3'b111, (cyc % 3) != 2};
                #1;
                if (clu_vld[0] && clu_rdy[0]) begin
                    int src;
                    int seq;
                    src = int'(clu_data[15:8]);
                    seq = int'(clu_data[7:0]);
                    if (src >= N || seq != rcv[src]) order_ok = 1'b0;
                    else rcv[src]++;
                end
                for (int b = 0; b < N; b++) if (bank_rdy[b]) sent[b]++;
                tick();
            end
            check(order_ok, "R10 order", 64'(order_ok), 64'h1);
            for (int b = 0; b < N; b++) begin
                check(rcv[b] == 6 && sent[b] == 6, "R10 count",
                      64'({sent[b], rcv[b]}), 64'h0000000600000006);
            end
            bank_vld = '0;
            load_words();
        end

        // R9 reset returns the all-on fold from a folded state.
        refold(0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        check(clu_pwr_en == 4'b1111, "R9 reset refold", 64'(clu_pwr_en), 64'hf);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule